// File: doc/BRIEF.md
# Multi-Master I2C Bus Monitor and Master Control Register

This block is the control and status register, together with the bus-condition watcher, for a controller that shares an I2C bus with other masters. It samples the raw SCL and SDA lines through synchronizer chains. On those samples it recognises START and STOP conditions and keeps a bus-busy flag from them. It also holds the master-mode request, the transfer direction and a baud-rate select that a separate clock generator reads.

A byte-transfer engine outside this block shifts the bits. It reports three things: the bit it is driving onto SDA at each bit sample point, the result of each acknowledge slot, and a strobe marking each slot. From these the block detects two kinds of arbitration loss and a missing acknowledge. It records each in a sticky flag that software clears by writing zero. On a loss or a missing acknowledge it drops master mode. On a line loss it also pulses a release output, so that the engine stops driving SDA. An interrupt request is raised while a flag is set and interrupts are enabled.

All pins are plain control and status signals. Nothing flows through the block as a stream, so there is no valid/ready handshake and no back-pressure.

Top module: `i2cm_bus_monitor`

## Requirements
- R1: After reset the register reads 0x00, irq and sda_release are 0, and master mode is off. The register layout from bit 7 down is: arbitration-lost flag (7), no-acknowledge flag (6), bus-busy (5), master mode (4), direction (3), baud select (2:0).
- R2: A START condition sets bus-busy (bit 5). A START is SDA going from 1 to 0 while SCL is 1, judged on two-flop synchronized samples.
- R3: A STOP condition clears bus-busy. A STOP is SDA going from 0 to 1 while SCL is 1. Bus-busy is held at 0 while enable is 0, and software writes to bit 5 have no effect.
- R4: A register write with bit 4 = 1, made while master mode is 0 and bus-busy is 1, is rejected. Master mode stays 0 and the arbitration-lost flag (bit 7) sets.
- R5: Line arbitration loss occurs when master mode is 1, arb_check is 1, drive_bit is 1 and synchronized SDA is 0. It sets bit 7, clears master mode and pulses sda_release for exactly one cycle. If drive_bit is 0, no loss is flagged.
- R6: An acknowledge slot (ack_valid = 1) with ack_nak = 1 while master mode is 1 sets the no-acknowledge flag (bit 6) and clears master mode. A missing acknowledge outside master mode, or an acknowledge that is received, leaves bit 6 unchanged.
- R7: Writing 0 to bit 7 or bit 6 clears that flag, and writing 1 has no effect. A hardware set or clear in the same cycle as a software write wins over the write.
- R8: irq is 1 exactly when irq_en is 1 and bit 7 or bit 6 is 1.
- R9: Bits 3:0 are plain read/write. Writing bit 4 = 1 while the bus is idle enters master mode, and writing 0 leaves it.
- R10: SDA changes while SCL is 0 are data, not bus conditions, and leave bus-busy unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Module enable; 0 forces bus-busy low |
| irq_en | input | 1 | Interrupt enable |
| scl_in | input | 1 | Raw SCL line level |
| sda_in | input | 1 | Raw SDA line level |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read value |
| arb_check | input | 1 | Engine strobe: compare the driven bit with the line now |
| drive_bit | input | 1 | Bit the engine is driving onto SDA |
| ack_valid | input | 1 | Engine strobe: acknowledge slot finished |
| ack_nak | input | 1 | Acknowledge slot result, 1 = no acknowledge |
| irq | output | 1 | Interrupt request |
| master_mode | output | 1 | Master mode bit |
| dir_rx | output | 1 | Direction bit |
| baud_sel | output | 3 | Baud-rate select |
| sda_release | output | 1 | One-cycle pulse: stop driving SDA after a lost arbitration |
| bus_busy | output | 1 | Bus-busy flag |
| start_seen | output | 1 | START detected this cycle |
| stop_seen | output | 1 | STOP detected this cycle |

## Verification
The condition detector is tried with four line patterns: SDA falling and rising while SCL is high, SDA toggling while SCL is low, and a START followed by a disable. These separate real bus conditions from data bit changes and from the disable path. Arbitration is tried on both causes, with the line compare run once with a driven 0 and once with a driven 1 against a low line, to show that only a driven 1 read as 0 counts. Acknowledge slots are given in and out of master mode and with and without an acknowledge. A write that clears a flag is made in the same cycle as a hardware set, to show which one wins.

// File: rtl/i2cm_pkg.sv
package i2cm_pkg;
  localparam int unsigned BAUD_W = 3;
  localparam int unsigned REG_W  = 5 + BAUD_W;

  typedef struct packed {
    logic              alif;
    logic              nakif;
    logic              busy;
    logic              mast;
    logic              dir;
    logic [BAUD_W-1:0] baud;
  } ctl_word_t;
endpackage

// File: rtl/i2cm_line_sync.sv
module i2cm_line_sync #(
  parameter int unsigned W      = 2,
  parameter int unsigned STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stg[0] <= RST_VAL;
    else        stg[0] <= din;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stg[s] <= RST_VAL;
      else        stg[s] <= stg[s-1];
    end
  end

  assign dout = stg[STAGES-1];
endmodule

// File: rtl/i2cm_cond_detect.sv
module i2cm_cond_detect (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_s,
  input  logic sda_s,
  output logic start_o,
  output logic stop_o
);
  logic scl_d, sda_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_d <= 1'b1;
      sda_d <= 1'b1;
    end else begin
      scl_d <= scl_s;
      sda_d <= sda_s;
    end
  end

  // A condition needs SCL high on both samples, so an SDA edge while SCL moves is data.
  logic scl_held;
  assign scl_held = scl_s & scl_d;
  assign start_o  = scl_held &  sda_d & ~sda_s;
  assign stop_o   = scl_held & ~sda_d &  sda_s;
endmodule

// File: rtl/i2cm_busy_track.sv
module i2cm_busy_track (
  input  logic clk,
  input  logic rst_n,
  input  logic enable,
  input  logic start_i,
  input  logic stop_i,
  output logic busy_o
);
  logic busy_q, busy_n;

  always_comb begin
    busy_n = busy_q;
    if (!enable)      busy_n = 1'b0;
    else if (start_i) busy_n = 1'b1;
    else if (stop_i)  busy_n = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) busy_q <= 1'b0;
    else        busy_q <= busy_n;
  end

  assign busy_o = busy_q;

  AST_BUSY_ON_START: assert property (@(posedge clk) disable iff (!rst_n)
    enable && start_i |=> busy_o); // R2
  AST_BUSY_OFF_STOP: assert property (@(posedge clk) disable iff (!rst_n)
    stop_i && !start_i |=> !busy_o); // R3
  AST_BUSY_OFF_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> !busy_o); // R3
  AST_BUSY_HOLD_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    enable && !start_i && !stop_i |=> $stable(busy_o)); // R10
endmodule

// File: rtl/i2cm_ctrl_regs.sv
module i2cm_ctrl_regs
  import i2cm_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              wr_alif,
  input  logic              wr_nakif,
  input  logic              wr_mast,
  input  logic              wr_dir,
  input  logic [BAUD_W-1:0] wr_baud,
  input  logic              busy_i,
  input  logic              sda_s,
  input  logic              arb_check,
  input  logic              drive_bit,
  input  logic              ack_valid,
  input  logic              ack_nak,
  input  logic              irq_en,
  output logic              alif_o,
  output logic              nakif_o,
  output logic              mast_o,
  output logic              dir_o,
  output logic [BAUD_W-1:0] baud_o,
  output logic              release_o,
  output logic              irq_o
);
  logic              alif_q, nakif_q, mast_q, dir_q, rel_q;
  logic [BAUD_W-1:0] baud_q;
  logic              alif_n, nakif_n, mast_n;

  logic line_loss, nak_hit, mast_req, mast_reject;
  assign line_loss   = mast_q & arb_check & drive_bit & ~sda_s;
  assign nak_hit     = mast_q & ack_valid & ack_nak;
  assign mast_req    = wr_en & wr_mast & ~mast_q;
  assign mast_reject = mast_req & busy_i;

  always_comb begin
    alif_n = alif_q;
    if (line_loss | mast_reject)  alif_n = 1'b1;
    else if (wr_en && !wr_alif)   alif_n = 1'b0;

    nakif_n = nakif_q;
    if (nak_hit)                  nakif_n = 1'b1;
    else if (wr_en && !wr_nakif)  nakif_n = 1'b0;

    mast_n = mast_q;
    if (line_loss | nak_hit)      mast_n = 1'b0;
    else if (wr_en)               mast_n = wr_mast & (mast_q | ~busy_i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      alif_q  <= 1'b0;
      nakif_q <= 1'b0;
      mast_q  <= 1'b0;
      dir_q   <= 1'b0;
      baud_q  <= '0;
      rel_q   <= 1'b0;
    end else begin
      alif_q  <= alif_n;
      nakif_q <= nakif_n;
      mast_q  <= mast_n;
      rel_q   <= line_loss;
      if (wr_en) begin
        dir_q  <= wr_dir;
        baud_q <= wr_baud;
      end
    end
  end

  assign alif_o    = alif_q;
  assign nakif_o   = nakif_q;
  assign mast_o    = mast_q;
  assign dir_o     = dir_q;
  assign baud_o    = baud_q;
  assign release_o = rel_q;
  assign irq_o     = irq_en & (alif_q | nakif_q);

  AST_LINE_LOSS_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    line_loss |=> alif_o && !mast_o && release_o); // R5
  AST_RELEASE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    release_o |=> !release_o); // R5
  AST_REJECT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    mast_reject |=> alif_o && !mast_o); // R4
  AST_NAK_DROPS_MASTER: assert property (@(posedge clk) disable iff (!rst_n)
    nak_hit |=> nakif_o && !mast_o); // R6
  AST_NAK_IDLE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    !mast_o && !nakif_o |=> !nakif_o); // R6
  AST_W1_NO_SET: assert property (@(posedge clk) disable iff (!rst_n)
    !alif_o && !line_loss && !mast_reject |=> !alif_o); // R7
  AST_W0_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && !wr_nakif && !nak_hit |=> !nakif_o); // R7
endmodule

// File: rtl/i2cm_bus_monitor.sv
module i2cm_bus_monitor
  import i2cm_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic              irq_en,
  input  logic              scl_in,
  input  logic              sda_in,
  input  logic              reg_wr,
  input  logic [REG_W-1:0]  reg_wdata,
  output logic [REG_W-1:0]  reg_rdata,
  input  logic              arb_check,
  input  logic              drive_bit,
  input  logic              ack_valid,
  input  logic              ack_nak,
  output logic              irq,
  output logic              master_mode,
  output logic              dir_rx,
  output logic [BAUD_W-1:0] baud_sel,
  output logic              sda_release,
  output logic              bus_busy,
  output logic              start_seen,
  output logic              stop_seen
);
  logic [1:0] lines_s;
  logic       scl_s, sda_s;

  i2cm_line_sync #(.W(2), .STAGES(SYNC_STAGES), .RST_VAL(2'b11)) u_sync (
    .clk (clk), .rst_n (rst_n), .din ({scl_in, sda_in}), .dout (lines_s)
  );
  assign scl_s = lines_s[1];
  assign sda_s = lines_s[0];

  i2cm_cond_detect u_cond (
    .clk (clk), .rst_n (rst_n), .scl_s (scl_s), .sda_s (sda_s),
    .start_o (start_seen), .stop_o (stop_seen)
  );

  i2cm_busy_track u_busy (
    .clk (clk), .rst_n (rst_n), .enable (enable),
    .start_i (start_seen), .stop_i (stop_seen), .busy_o (bus_busy)
  );

  ctl_word_t wr_word, rd_word;
  assign wr_word = ctl_word_t'(reg_wdata);

  logic alif, nakif;

  i2cm_ctrl_regs u_regs (
    .clk (clk), .rst_n (rst_n), .wr_en (reg_wr),
    .wr_alif (wr_word.alif), .wr_nakif (wr_word.nakif), .wr_mast (wr_word.mast),
    .wr_dir (wr_word.dir), .wr_baud (wr_word.baud),
    .busy_i (bus_busy), .sda_s (sda_s),
    .arb_check (arb_check), .drive_bit (drive_bit),
    .ack_valid (ack_valid), .ack_nak (ack_nak), .irq_en (irq_en),
    .alif_o (alif), .nakif_o (nakif), .mast_o (master_mode),
    .dir_o (dir_rx), .baud_o (baud_sel), .release_o (sda_release), .irq_o (irq)
  );

  always_comb begin
    rd_word.alif  = alif;
    rd_word.nakif = nakif;
    rd_word.busy  = bus_busy;
    rd_word.mast  = master_mode;
    rd_word.dir   = dir_rx;
    rd_word.baud  = baud_sel;
  end
  assign reg_rdata = rd_word;

  AST_BUSY_READ_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr && wr_word.busy && !bus_busy && !start_seen |=> !bus_busy); // R3
  AST_PLAIN_BITS: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr |=> dir_rx == $past(wr_word.dir) && baud_sel == $past(wr_word.baud)); // R9
endmodule

// File: tb/i2cm_bus_monitor_bench.sv
module i2cm_bus_monitor_bench;
  localparam int CLK_P = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic enable = 1'b1, irq_en = 1'b0;
  logic reg_wr = 1'b0;
  logic [7:0] reg_wdata = 8'h00, reg_rdata;
  logic arb_check = 1'b0, drive_bit = 1'b0, ack_valid = 1'b0, ack_nak = 1'b0;
  logic irq, master_mode, dir_rx, sda_release, bus_busy, start_seen, stop_seen;
  logic [2:0] baud_sel;

  // open-drain lines: this master and one other driver
  logic sda_m_low = 1'b0, sda_o_low = 1'b0, scl_m_low = 1'b0, scl_o_low = 1'b0;
  wire  sda_line = !(sda_m_low || sda_o_low);
  wire  scl_line = !(scl_m_low || scl_o_low);

  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  i2cm_bus_monitor u_i2cm_bus_monitor (
    .clk (clk), .rst_n (rst_n), .enable (enable), .irq_en (irq_en),
    .scl_in (scl_line), .sda_in (sda_line),
    .reg_wr (reg_wr), .reg_wdata (reg_wdata), .reg_rdata (reg_rdata),
    .arb_check (arb_check), .drive_bit (drive_bit),
    .ack_valid (ack_valid), .ack_nak (ack_nak),
    .irq (irq), .master_mode (master_mode), .dir_rx (dir_rx), .baud_sel (baud_sel),
    .sda_release (sda_release), .bus_busy (bus_busy),
    .start_seen (start_seen), .stop_seen (stop_seen)
  );

  task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got=%02h exp=%02h", tag, got, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [7:0] d);
    reg_wr = 1'b1; reg_wdata = d;
    step(1);
    reg_wr = 1'b0;
  endtask

  task automatic t_reset;
    chk("R1 reset reg", reg_rdata, 8'h00);
    chk("R1 reset irq/release", {6'd0, irq, sda_release}, 8'h00);
  endtask

  task automatic t_start_stop;
    sda_o_low = 1'b1; step(5);
    chk("R2 start sets busy", reg_rdata, 8'h20);
    scl_o_low = 1'b1; step(4);
    sda_o_low = 1'b0; step(4);
    chk("R10 sda rise with scl low", {7'd0, bus_busy}, 8'h01);
    sda_o_low = 1'b1; step(4);
    scl_o_low = 1'b0; step(4);
    chk("R10 data bits keep busy", reg_rdata, 8'h20);
    sda_o_low = 1'b0; step(5);
    chk("R3 stop clears busy", reg_rdata, 8'h00);
  endtask

  task automatic t_disable;
    sda_o_low = 1'b1; step(5);
    chk("R2 second start", {7'd0, bus_busy}, 8'h01);
    enable = 1'b0; step(1);
    chk("R3 disable clears busy", {7'd0, bus_busy}, 8'h00);
    enable = 1'b1; step(3);
    chk("R3 no busy without new start", {7'd0, bus_busy}, 8'h00);
    sda_o_low = 1'b0; step(5);
    wr(8'h20);
    chk("R3 busy bit read-only", reg_rdata, 8'h00);
  endtask

  task automatic t_plain_bits;
    wr(8'h0D);
    chk("R9 dir/baud write", reg_rdata, 8'h0D);
    wr(8'h1A);
    chk("R9 master set when idle", reg_rdata, 8'h1A);
    wr(8'h00);
    chk("R9 master cleared by write 0", reg_rdata, 8'h00);
  endtask

  task automatic t_reject;
    sda_o_low = 1'b1; step(5);
    wr(8'h10);
    chk("R4 master request rejected when busy", reg_rdata, 8'hA0);
    irq_en = 1'b1; step(1);
    chk("R8 irq on with alif", {7'd0, irq}, 8'h01);
    irq_en = 1'b0; step(1);
    chk("R8 irq off when disabled", {7'd0, irq}, 8'h00);
    wr(8'h80);
    chk("R7 write 1 keeps alif", reg_rdata, 8'hA0);
    wr(8'h00);
    chk("R7 write 0 clears alif", reg_rdata, 8'h20);
    irq_en = 1'b1; step(1);
    chk("R8 irq off with no flag", {7'd0, irq}, 8'h00);
    irq_en = 1'b0;
    sda_o_low = 1'b0; step(5);
  endtask

  task automatic t_line_arb;
    wr(8'h10);
    sda_m_low = 1'b1; step(5);
    chk("R2 own start, master", reg_rdata, 8'h30);
    arb_check = 1'b1; drive_bit = 1'b0; step(1);
    arb_check = 1'b0;
    chk("R5 driven 0 read 0 not a loss", reg_rdata, 8'h30);
    scl_m_low = 1'b1; step(3);
    sda_o_low = 1'b1; step(1);
    sda_m_low = 1'b0; step(2);
    scl_m_low = 1'b0; step(5);
    arb_check = 1'b1; drive_bit = 1'b1; step(1);
    arb_check = 1'b0; drive_bit = 1'b0;
    chk("R5 line loss flag, master dropped", reg_rdata, 8'hA0);
    chk("R5 release pulse", {7'd0, sda_release}, 8'h01);
    step(1);
    chk("R5 release one cycle", {7'd0, sda_release}, 8'h00);
    wr(8'h00);
    sda_o_low = 1'b0; step(5);
    chk("R3 stop after loss", reg_rdata, 8'h00);
  endtask

  task automatic t_nak;
    wr(8'h10);
    ack_valid = 1'b1; ack_nak = 1'b1; step(1);
    ack_valid = 1'b0; ack_nak = 1'b0;
    chk("R6 nak sets flag, drops master", reg_rdata, 8'h40);
    irq_en = 1'b1; step(1);
    chk("R8 irq from nak flag", {7'd0, irq}, 8'h01);
    irq_en = 1'b0;
    wr(8'h00);
    chk("R7 write 0 clears nak flag", reg_rdata, 8'h00);
    ack_valid = 1'b1; ack_nak = 1'b1; step(1);
    ack_valid = 1'b0; ack_nak = 1'b0;
    chk("R6 nak outside master ignored", reg_rdata, 8'h00);
    wr(8'h10);
    ack_valid = 1'b1; ack_nak = 1'b0; step(1);
    ack_valid = 1'b0;
    chk("R6 ack received keeps master", reg_rdata, 8'h10);
  endtask

  task automatic t_priority;
    ack_valid = 1'b1; ack_nak = 1'b1; reg_wr = 1'b1; reg_wdata = 8'h10; step(1);
    ack_valid = 1'b0; ack_nak = 1'b0; reg_wr = 1'b0;
    chk("R7 hw set/clear beats write", reg_rdata, 8'h40);
    wr(8'h00);
    chk("R7 cleared after priority test", reg_rdata, 8'h00);
  endtask

  initial begin
    step(3);
    rst_n = 1'b1;
    step(2);
    t_reset();
    t_start_stop();
    t_disable();
    t_plain_bits();
    t_reject();
    t_line_arb();
    t_nak();
    t_priority();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_P * 200000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule